// File: doc/BRIEF.md
# Multi-Background Word March Self-Test Controller

This controller drives a synchronous single-port word RAM through a five-operation march. First it writes a data background to every address. It then walks the addresses upward: at each one it reads the background back and writes the complement. Finally it walks downward from the top address to address 0: at each one it reads the complement and writes the background back. The march runs once for each of several backgrounds. The first background is all zeros. Each further background is built from one bit of the index of each bit position within the word. As a result, every pair of bits in a word is held at equal values in some passes and at opposite values in others. This exposes couplings inside a word that a solid pattern cannot excite.

A single start pulse launches the whole sequence. The step order is sampled at that moment: the row field advances fastest, or the column field advances fastest. Every read is compared with the expected word. The first mismatching address is kept, and a sticky fail flag is raised. A done flag marks completion. The RAM side is a plain request port that accepts one operation per cycle and returns read data one cycle after the read is issued. The port has no back-pressure, because the RAM never stalls, so no valid/ready handshake is needed. The controller issues exactly one operation in every busy cycle.

Top module: `mbist_mats_wb`

## Requirements
- R1: While reset is held and after it is released, done_o and fail_o are 0, fail_addr_o is 0 and mem_en_o is 0.
- R2: There are NUM_BG = log2(DATA_W)+1 backgrounds, applied in the order k = 0, 1, ... NUM_BG-1. Background 0 is all zeros. For k >= 1, bit b of the background equals bit k-1 of the binary value of b. For a 4-bit word these are 4'b0000, 4'b1010 and 4'b1100.
- R3: For each background the operations are as follows. First, N writes of the background at logical indices 0..N-1. Second, for indices 0..N-1, a read followed by a write of the complement at the same address. Third, for indices N-1 down to 0, a read followed by a write of the background at the same address. One operation is issued per cycle (mem_en_o=1), and mem_we_o=1 marks a write.
- R4: The address is {row, col}, with col in the low COL_BITS bits. With row_fast_i=0 at start, logical index i drives address i. With row_fast_i=1, the row field takes i[ROW_BITS-1:0] and the column field takes i[ADDR_W-1:ROW_BITS].
- R5: A run issues exactly 5*NUM_BG*N operations in consecutive cycles. done_o rises in the cycle after the last one and stays 1, with mem_en_o at 0, until the next accepted start.
- R6: mem_rdata_i in the cycle after a read is compared with the expected word: the background in the upward pass and the complement in the downward pass. Any mismatch sets fail_o, which stays set until the next accepted start.
- R7: fail_addr_o holds the address of the first mismatching read of the run. Later mismatches leave it unchanged.
- R8: A start pulse and any change of row_fast_i while a run is in progress are ignored. The operation sequence and its length are unaffected.
- R9: An accepted start clears done_o, fail_o and fail_addr_o at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| row_fast_i | input | 1 | Step order, sampled at start: 1 = row field fastest |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ROW_BITS+COL_BITS | First failing address |
| mem_en_o | output | 1 | RAM operation request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ROW_BITS+COL_BITS | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the read |

## Verification
Two functions of the block can fall in the same cycle. The comparison of the last read of the whole run lands in the cycle where the final write is issued, so the fail capture and the end-of-run transition to done register at the same clock edge. The bench provokes this by corrupting the very last read of a run. It also corrupts every other read position in turn, in both step orders. For each run it judges that done rises on the exact cycle count and that fail_o is set. It also checks that fail_addr_o equals the address computed arithmetically from the corrupted read's position.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_UP   = 2'd2,
    PH_DOWN = 2'd3
  } phase_e;
endpackage

// File: rtl/mbist_bg_gen.sv
module mbist_bg_gen #(
  parameter int DATA_W = 4,
  parameter int NUM_BG = $clog2(DATA_W) + 1,
  parameter int BGI_W  = (NUM_BG > 1) ? $clog2(NUM_BG) : 1
) (
  input  logic [BGI_W-1:0]  bg_idx_i,
  output logic [DATA_W-1:0] bg_o
);
  // Background k>=1: bit b carries bit k-1 of the position index b.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      bg_o[b] = 1'b0;
      for (int k = 1; k < NUM_BG; k++) begin
        if (bg_idx_i == BGI_W'(k)) bg_o[b] = ((b >> (k - 1)) & 1) != 0;
      end
    end
  end
endmodule

// File: rtl/mbist_addr_map.sv
module mbist_addr_map #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W = ROW_BITS + COL_BITS
) (
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              row_fast_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] swapped;
  // Row field (upper bits) takes the fast-moving low index bits.
  assign swapped = {idx_i[ROW_BITS-1:0], idx_i[ADDR_W-1:ROW_BITS]};
  assign addr_o  = row_fast_i ? swapped : idx_i;
endmodule

// File: rtl/mbist_fail_capture.sv
module mbist_fail_capture #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  logic mismatch;
  assign mismatch = cmp_en_i && (rdata_i != exp_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
    end else if (mismatch && !fail_o) begin
      fail_o      <= 1'b1;
      fail_addr_o <= addr_i;
    end
  end

  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clear_i) |=> fail_o);

  assert_first_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clear_i) |=> $stable(fail_addr_o));
endmodule

// File: rtl/mbist_mats_wb.sv
module mbist_mats_wb
  import mbist_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         row_fast_i,
  output logic                         done_o,
  output logic                         fail_o,
  output logic [ROW_BITS+COL_BITS-1:0] fail_addr_o,
  output logic                         mem_en_o,
  output logic                         mem_we_o,
  output logic [ROW_BITS+COL_BITS-1:0] mem_addr_o,
  output logic [DATA_W-1:0]            mem_wdata_o,
  input  logic [DATA_W-1:0]            mem_rdata_i
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int NUM_BG = $clog2(DATA_W) + 1;
  localparam int BGI_W  = (NUM_BG > 1) ? $clog2(NUM_BG) : 1;
  localparam logic [ADDR_W-1:0] IDX_TOP = '1;
  localparam logic [BGI_W-1:0]  BG_LAST = BGI_W'(NUM_BG - 1);

  phase_e            state_q;
  logic [ADDR_W-1:0] idx_q;
  logic              wr_phase_q;
  logic [BGI_W-1:0]  bg_idx_q;
  logic              mode_q;
  logic              done_q;
  logic              accept;
  logic [DATA_W-1:0] bg;
  logic              rd_pend_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] rd_addr_q;

  assign accept = start_i && (state_q == PH_IDLE);

  mbist_bg_gen #(.DATA_W(DATA_W), .NUM_BG(NUM_BG), .BGI_W(BGI_W)) bg_i (
    .bg_idx_i(bg_idx_q),
    .bg_o    (bg)
  );

  mbist_addr_map #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) map_i (
    .idx_i     (idx_q),
    .row_fast_i(mode_q),
    .addr_o    (mem_addr_o)
  );

  // Operation issue, decoded from the phase.
  always_comb begin
    mem_en_o    = (state_q != PH_IDLE);
    mem_we_o    = (state_q == PH_INIT) || wr_phase_q;
    mem_wdata_o = (state_q == PH_UP) ? ~bg : bg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      idx_q      <= '0;
      wr_phase_q <= 1'b0;
      bg_idx_q   <= '0;
      mode_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      case (state_q)
        PH_IDLE: if (accept) begin
          state_q    <= PH_INIT;
          idx_q      <= '0;
          wr_phase_q <= 1'b0;
          bg_idx_q   <= '0;
          mode_q     <= row_fast_i;
          done_q     <= 1'b0;
        end
        PH_INIT: begin
          if (idx_q == IDX_TOP) begin
            idx_q   <= '0;
            state_q <= PH_UP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_UP: begin
          wr_phase_q <= !wr_phase_q;
          if (wr_phase_q) begin
            if (idx_q == IDX_TOP) state_q <= PH_DOWN;
            else idx_q <= idx_q + 1'b1;
          end
        end
        default: begin
          wr_phase_q <= !wr_phase_q;
          if (wr_phase_q) begin
            if (idx_q != '0) begin
              idx_q <= idx_q - 1'b1;
            end else if (bg_idx_q == BG_LAST) begin
              state_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              bg_idx_q <= bg_idx_q + 1'b1;
              state_q  <= PH_INIT;
            end
          end
        end
      endcase
    end
  end

  // Read pipeline: expected word and address wait one cycle for the data.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      exp_q     <= '0;
      rd_addr_q <= '0;
    end else begin
      rd_pend_q <= mem_en_o && !mem_we_o;
      exp_q     <= (state_q == PH_UP) ? bg : ~bg;
      rd_addr_q <= mem_addr_o;
    end
  end

  mbist_fail_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) cap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept),
    .cmp_en_i   (rd_pend_q),
    .exp_i      (exp_q),
    .addr_i     (rd_addr_q),
    .rdata_i    (mem_rdata_i),
    .fail_o     (fail_o),
    .fail_addr_o(fail_addr_o)
  );

  assign done_o = done_q;

  assert_rw_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |=> (mem_en_o && mem_we_o && mem_addr_o == $past(mem_addr_o)));

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_en_o);

  assert_bg_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |=> (bg_idx_q == $past(bg_idx_q) || bg_idx_q == $past(bg_idx_q) + 1'b1));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE && !(state_q == PH_DOWN && wr_phase_q && idx_q == '0)) |=> $stable(mode_q));
endmodule

// File: tb/mbist_mats_wb_tb_top.sv
`timescale 1ns/1ps
module mbist_mats_wb_tb_top;
  localparam int DW  = 4;
  localparam int RB  = 2;
  localparam int CB  = 2;
  localparam int AW  = RB + CB;
  localparam int N   = 1 << AW;
  localparam int K   = 3;
  localparam int OPS = 5 * K * N;
  localparam int RDS = 2 * K * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic row_fast = 1'b0;
  logic done, fail, mem_en, mem_we;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  mbist_mats_wb #(.DATA_W(DW), .ROW_BITS(RB), .COL_BITS(CB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .row_fast_i(row_fast),
    .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  int total = 0;
  int bad = 0;

  // Run parameters, written only by the stimulus.
  int  corrupt_r = -1;
  bit  bridge = 1'b0;
  bit  mode_run = 1'b0;
  int  rd_base = 0;
  int  op_base = 0;

  // Written only by the model and the monitor.
  int rd_cnt = 0;
  int op_cnt = 0;
  int op_err = 0;

  logic [DW-1:0] mem [N];

  function automatic logic [DW-1:0] bg_f(int k);
    logic [DW-1:0] v;
    for (int b = 0; b < DW; b++) v[b] = (k == 0) ? 1'b0 : (((b >> (k - 1)) & 1) != 0);
    return v;
  endfunction

  function automatic logic [AW-1:0] map_f(int i, bit m);
    logic [AW-1:0] li;
    li = AW'(i);
    return m ? {li[RB-1:0], li[AW-1:RB]} : li;
  endfunction

  // RAM model with one-cycle read latency and optional faults.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        logic [DW-1:0] w;
        w = mem_wdata;
        if (bridge) w[2] = w[0];
        mem[mem_addr] <= w;
      end else begin
        logic [DW-1:0] m;
        m = '0;
        if (corrupt_r >= 0 && (rd_cnt - rd_base) == corrupt_r) m[(rd_cnt - rd_base) % DW] = 1'b1;
        mem_rdata <= mem[mem_addr] ^ m;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // Operation monitor: each issued operation against the arithmetic sequence (R2, R3, R4).
  always @(negedge clk) begin
    if (rst_n && mem_en) begin
      int r, kb, q, j, li;
      logic ew;
      logic [DW-1:0] ed, bv;
      r = op_cnt - op_base;
      kb = r / (5 * N);
      q = r % (5 * N);
      bv = bg_f(kb);
      if (q < N) begin
        ew = 1'b1; li = q; ed = bv;
      end else if (q < 3 * N) begin
        j = q - N; li = j / 2; ew = (j % 2) == 1; ed = ~bv;
      end else begin
        j = q - 3 * N; li = N - 1 - j / 2; ew = (j % 2) == 1; ed = bv;
      end
      if (r >= OPS || mem_we !== ew || mem_addr !== map_f(li, mode_run) || (ew && mem_wdata !== ed))
        op_err <= op_err + 1;
      op_cnt <= op_cnt + 1;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(bit m, int cr, bit br, bit poke, bit exp_fail, int exp_addr);
    int cycles;
    int err0;
    @(negedge clk);
    corrupt_r = cr;
    bridge = br;
    mode_run = m;
    rd_base = rd_cnt;
    op_base = op_cnt;
    err0 = op_err;
    row_fast = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && !fail && fail_addr == '0, "R9", "clear on start", {done, fail}, 0);
    cycles = 0;
    while (!done && cycles < 1000) begin
      if (poke && cycles == 50) begin start = 1'b1; row_fast = !m; end
      if (poke && cycles == 51) start = 1'b0;
      if (br && cycles == 2 * 5 * N + 8) check(!fail, "R2", "no fail before bg2 read", fail, 0);
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check(cycles == OPS, "R5", "cycles to done", cycles, OPS);
    check(op_cnt - op_base == OPS, poke ? "R8" : "R5", "op count", op_cnt - op_base, OPS);
    check(op_err == err0, "R3/R4", "op sequence errors", op_err - err0, 0);
    check(fail == exp_fail, "R6", "fail flag", fail, exp_fail);
    if (exp_fail) check(fail_addr == AW'(exp_addr), "R7", "fail address", fail_addr, exp_addr);
    repeat (3) @(negedge clk);
    check(done && !mem_en, "R5", "done holds, port idle", {done, mem_en}, 2);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !fail && !mem_en && fail_addr == '0, "R1", "reset state", {done, fail, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !fail && !mem_en, "R1", "after reset", {done, fail, mem_en}, 0);
    // clean runs in both step orders
    run(1'b0, -1, 1'b0, 1'b0, 1'b0, 0);
    run(1'b1, -1, 1'b0, 1'b0, 1'b0, 0);
    // start and mode change mid-run ignored (R8)
    run(1'b0, -1, 1'b0, 1'b1, 1'b0, 0);
    // intraword bridge: bit2 copies bit0; first seen at first read of background 2 (R2)
    run(1'b0, -1, 1'b1, 1'b0, 1'b1, 0);
    // every read position corrupted, both orders; last one coincides with done (R6, R7)
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < RDS; r++) begin
        int q, li;
        q = r % (2 * N);
        li = (q < N) ? q : (N - 1 - (q - N));
        run(m[0], r, 1'b0, 1'b0, 1'b1, int'(map_f(li, m[0])));
      end
    end
    // clean run after failures: fail cleared (R9)
    run(1'b1, -1, 1'b0, 1'b0, 1'b0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule